// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

This block is a 64-word by 36-bit first-in first-out buffer that joins two independent clock domains. A producer writes on port A with its own clock, and a consumer reads on port B with another clock. Each port access happens on a rising clock edge only when that port's select is low, its enable is high and its direction input asks for the operation the port serves. Port A serves writes and port B serves reads.

The write side drives an active-low full flag and an active-low almost-full flag. The read side drives an active-low empty flag and an active-low almost-empty flag. Each flag is computed only from state held in its own domain. The pointers cross between the domains as Gray code through two-flop synchronisers. The almost-flag threshold X is one of four presets, chosen by a two-bit select and captured on the rising edge of reset. Read data comes from an output register that loads at the read edge.

Top module: `twoclk_fifo`

## Requirements
- R1: A word is stored on a rising `a_clk` edge only when `a_sel_n`=0, `a_en`=1, `a_wr`=1 and `a_full_n`=1. If any one of these conditions is missing, nothing is stored.
- R2: A word is read on a rising `b_clk` edge only when `b_sel_n`=0, `b_en`=1, `b_wr`=0 and `b_empty_n`=1. After that edge, `b_q` holds the oldest stored word, and words leave in the order they were written.
- R3: `a_full_n` is low while reset is low. After reset rises it stays low at the first rising `a_clk` edge and goes high at the second. It is low whenever 64 words are stored and high otherwise.
- R4: `b_empty_n` is low while reset is low and whenever no word is stored. After a write into an empty buffer, it stays low past the first rising `b_clk` edge and goes high at the second.
- R5: `b_aempty_n` is low when the stored word count is at most X, and high otherwise.
- R6: `a_afull_n` is low when the number of free locations (64 minus the count) is at most X, and high otherwise.
- R7: X is taken from `off_sel` at the rising edge of `rst_n`, with 00→16, 01→12, 10→8 and 11→4. Changes on `off_sel` after that edge have no effect.
- R8: A write attempted while `a_full_n` is low leaves the contents unchanged. A read attempted while `b_empty_n` is low leaves `b_q` unchanged.
- R9: Holding `rst_n` low for at least four rising edges of each clock empties the buffer. While it is held, `a_afull_n` is high, and `b_empty_n`, `b_aempty_n` and `a_full_n` are low.
- R10: Under reads and writes that run at the same time on the two clocks, every written word is read back exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset; its rising edge captures `off_sel` |
| off_sel | input | 2 | Almost-flag threshold select |
| a_clk | input | 1 | Write-side clock |
| a_sel_n | input | 1 | Write-port select, active low |
| a_en | input | 1 | Write-port enable |
| a_wr | input | 1 | Direction, 1 = write |
| a_d | input | 36 | Write data |
| a_full_n | output | 1 | Full flag, active low |
| a_afull_n | output | 1 | Almost-full flag, active low |
| b_clk | input | 1 | Read-side clock |
| b_sel_n | input | 1 | Read-port select, active low |
| b_en | input | 1 | Read-port enable |
| b_wr | input | 1 | Direction, 0 = read |
| b_q | output | 36 | Output register |
| b_empty_n | output | 1 | Empty flag, active low |
| b_aempty_n | output | 1 | Almost-empty flag, active low |

## Verification
A write on `a_clk` and a read on `b_clk` can land in the same instant. At that moment each side acts on a pointer copy from the other side that is one synchroniser behind. One phase runs a writer and a reader concurrently, each pausing at random and acting only while its own flag permits. Every word read is compared against the bench's queue of accepted writes. Further stress comes from writes pressed against a full buffer and reads pressed against an empty one, both judged afterwards through the data that comes out.

// File: rtl/twoclk_fifo.sv
module twoclk_fifo #(
  parameter int DW   = 36,
  parameter int AW   = 6,
  parameter int OFF0 = 16,
  parameter int OFF1 = 12,
  parameter int OFF2 = 8,
  parameter int OFF3 = 4
) (
  input  logic          rst_n,
  input  logic [1:0]    off_sel,
  input  logic          a_clk,
  input  logic          a_sel_n,
  input  logic          a_en,
  input  logic          a_wr,
  input  logic [DW-1:0] a_d,
  output logic          a_full_n,
  output logic          a_afull_n,
  input  logic          b_clk,
  input  logic          b_sel_n,
  input  logic          b_en,
  input  logic          b_wr,
  output logic [DW-1:0] b_q,
  output logic          b_empty_n,
  output logic          b_aempty_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] off_q;
  logic [1:0]    a_rst_s, b_rst_s;
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rg_s1, rg_s2, wg_s1, wg_s2;
  logic [PW-1:0] a_used, b_used, a_free;
  logic          a_live, b_live, do_wr, do_rd;

  always_ff @(posedge rst_n) begin
    case (off_sel)
      2'd0:    off_q <= PW'(OFF0);
      2'd1:    off_q <= PW'(OFF1);
      2'd2:    off_q <= PW'(OFF2);
      default: off_q <= PW'(OFF3);
    endcase
  end

  // write domain
  assign do_wr = a_full_n && !a_sel_n && a_en && a_wr;

  always_ff @(posedge a_clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rst_s <= '0;
      wbin    <= '0;
      wgray   <= '0;
      rg_s1   <= '0;
      rg_s2   <= '0;
    end else begin
      a_rst_s <= {a_rst_s[0], 1'b1};
      rg_s1   <= rgray;
      rg_s2   <= rg_s1;
      if (do_wr) begin
        wbin  <= wbin + 1'b1;
        wgray <= to_gray(wbin + 1'b1);
      end
    end
  end

  always_ff @(posedge a_clk) begin
    if (do_wr) mem[wbin[AW-1:0]] <= a_d;
  end

  assign a_live    = a_rst_s[1];
  assign a_used    = wbin - to_bin(rg_s2);
  assign a_free    = PW'(DEPTH) - a_used;
  assign a_full_n  = a_live && (wgray != {~rg_s2[PW-1:PW-2], rg_s2[PW-3:0]});
  assign a_afull_n = !a_live || (a_free > off_q);

  // read domain
  assign do_rd = b_empty_n && !b_sel_n && b_en && !b_wr;

  always_ff @(posedge b_clk or negedge rst_n) begin
    if (!rst_n) begin
      b_rst_s <= '0;
      rbin    <= '0;
      rgray   <= '0;
      wg_s1   <= '0;
      wg_s2   <= '0;
      b_q     <= '0;
    end else begin
      b_rst_s <= {b_rst_s[0], 1'b1};
      wg_s1   <= wgray;
      wg_s2   <= wg_s1;
      if (do_rd) begin
        b_q   <= mem[rbin[AW-1:0]];
        rbin  <= rbin + 1'b1;
        rgray <= to_gray(rbin + 1'b1);
      end
    end
  end

  assign b_live     = b_rst_s[1];
  assign b_used     = to_bin(wg_s2) - rbin;
  assign b_empty_n  = b_live && (rgray != wg_s2);
  assign b_aempty_n = b_live && (b_used > off_q);

  assert_no_overflow_R8: assert property (@(posedge a_clk) disable iff (!rst_n)
    !a_full_n |=> wbin == $past(wbin));

  assert_no_underflow_R8: assert property (@(posedge b_clk) disable iff (!rst_n)
    !b_empty_n |=> rbin == $past(rbin));

  assert_count_bound_R1: assert property (@(posedge a_clk) disable iff (!rst_n)
    a_used <= PW'(DEPTH));

  assert_full_at_depth_R3: assert property (@(posedge a_clk) disable iff (!rst_n)
    (a_live && a_used == PW'(DEPTH)) |-> !a_full_n);

  assert_empty_means_ae_R5: assert property (@(posedge b_clk) disable iff (!rst_n)
    (b_live && !b_empty_n) |-> !b_aempty_n);

  assert_full_means_af_R6: assert property (@(posedge a_clk) disable iff (!rst_n)
    (a_live && !a_full_n) |-> !a_afull_n);
endmodule

// File: tb/sim_twoclk_fifo.sv
`timescale 1ns/100ps
module sim_twoclk_fifo;
  localparam int DEPTH = 64;

  logic        rst_n = 0;
  logic [1:0]  off_sel = 0;
  logic        a_clk = 0, b_clk = 0;
  logic        a_sel_n = 1, a_en = 0, a_wr = 0;
  logic [35:0] a_d = 0;
  logic        b_sel_n = 1, b_en = 0, b_wr = 0;
  wire  [35:0] b_q;
  wire         a_full_n, a_afull_n, b_empty_n, b_aempty_n;

  twoclk_fifo u0 (
    .rst_n(rst_n), .off_sel(off_sel),
    .a_clk(a_clk), .a_sel_n(a_sel_n), .a_en(a_en), .a_wr(a_wr), .a_d(a_d),
    .a_full_n(a_full_n), .a_afull_n(a_afull_n),
    .b_clk(b_clk), .b_sel_n(b_sel_n), .b_en(b_en), .b_wr(b_wr), .b_q(b_q),
    .b_empty_n(b_empty_n), .b_aempty_n(b_aempty_n)
  );

  always #2.5 a_clk = ~a_clk;
  always #4   b_clk = ~b_clk;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [35:0] model[$];
  logic [35:0] last_q = 0;
  int xoff = 16;

  function automatic int preset(input logic [1:0] s);
    case (s)
      2'd0: return 16;
      2'd1: return 12;
      2'd2: return 8;
      default: return 4;
    endcase
  endfunction

  function automatic logic exp_ae_n(input int cnt, input int x); return !(cnt <= x); endfunction
  function automatic logic exp_af_n(input int cnt, input int x); return !((DEPTH - cnt) <= x); endfunction

  function automatic logic [35:0] rnd36();
    return {$urandom, $urandom} & 36'hF_FFFF_FFFF;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_flags();
    int c = model.size();
    chk(a_full_n === (c != DEPTH), "R3 full flag", a_full_n, c != DEPTH);
    chk(b_empty_n === (c != 0), "R4 empty flag", b_empty_n, c != 0);
    chk(b_aempty_n === exp_ae_n(c, xoff), "R5 almost-empty", b_aempty_n, exp_ae_n(c, xoff));
    chk(a_afull_n === exp_af_n(c, xoff), "R6 almost-full", a_afull_n, exp_af_n(c, xoff));
  endtask

  task automatic settle();
    repeat (3) @(posedge a_clk);
    repeat (3) @(posedge b_clk);
    #0.3;
  endtask

  task automatic wr_op(input logic [35:0] d, input logic sn, input logic en, input logic wr);
    @(negedge a_clk);
    a_d = d; a_sel_n = sn; a_en = en; a_wr = wr;
    @(posedge a_clk);
    #0.3;
    a_sel_n = 1; a_en = 0; a_wr = 0;
    if (!sn && en && wr && model.size() < DEPTH) model.push_back(d);
  endtask

  task automatic rd_op(input logic sn, input logic en, input logic wr);
    @(negedge b_clk);
    b_sel_n = sn; b_en = en; b_wr = wr;
    @(posedge b_clk);
    #0.3;
    b_sel_n = 1; b_en = 0; b_wr = 0;
    if (!sn && en && !wr && model.size() > 0) begin
      last_q = model.pop_front();
      chk(b_q === last_q, "R2 read data", b_q, last_q);
    end else begin
      chk(b_q === last_q, "R8 output held on ignored read", b_q, last_q);
    end
  endtask

  task automatic rst_seq(input logic [1:0] s);
    a_sel_n = 1; a_en = 0; b_sel_n = 1; b_en = 0;
    @(negedge a_clk);
    rst_n = 0; off_sel = s;
    repeat (5) @(posedge b_clk);
    #0.3;
    chk(a_full_n === 1'b0, "R9 full low in reset", a_full_n, 0);
    chk(a_afull_n === 1'b1, "R9 almost-full high in reset", a_afull_n, 1);
    chk(b_empty_n === 1'b0, "R9 empty low in reset", b_empty_n, 0);
    chk(b_aempty_n === 1'b0, "R9 almost-empty low in reset", b_aempty_n, 0);
    model.delete();
    last_q = 0;
    xoff = preset(s);
    @(negedge a_clk);
    #0.2;
    rst_n = 1;
    #1;
    off_sel = ~s;
    @(posedge a_clk);
    #0.3;
    chk(a_full_n === 1'b0, "R3 full low at first edge after reset", a_full_n, 0);
    @(posedge a_clk);
    #0.3;
    chk(a_full_n === 1'b1, "R3 full high at second edge after reset", a_full_n, 1);
    settle();
    chk_flags();
  endtask

  task automatic fill_drain();
    for (int i = 0; i <= DEPTH; i++) begin
      wr_op(rnd36(), 0, 1, 1);
      settle();
      chk_flags();
    end
    for (int i = 0; i <= DEPTH; i++) begin
      rd_op(0, 1, 0);
      settle();
      chk_flags();
    end
  endtask

  initial begin
    int unsigned seed = $urandom(32'd2024);
    int got;
    rst_seq(2'd0);

    // R4: empty flag timing after the first word
    wr_op(36'h0_1234_5678, 0, 1, 1);
    @(posedge b_clk);
    #0.3;
    chk(b_empty_n === 1'b0, "R4 empty still low after first read edge", b_empty_n, 0);
    @(posedge b_clk);
    #0.3;
    chk(b_empty_n === 1'b1, "R4 empty high at second read edge", b_empty_n, 1);
    rd_op(0, 1, 0);
    settle();
    chk_flags();

    // R1: unqualified writes; R2: unqualified reads
    wr_op(36'h1, 1, 1, 1);
    wr_op(36'h2, 0, 0, 1);
    wr_op(36'h3, 0, 1, 0);
    settle();
    chk(b_empty_n === 1'b0, "R1 unqualified writes store nothing", b_empty_n, 0);
    wr_op(36'hA_5A5A_5A5A, 0, 1, 1);
    settle();
    rd_op(1, 1, 0);
    rd_op(0, 0, 0);
    rd_op(0, 1, 1);
    settle();
    chk(b_empty_n === 1'b1, "R2 unqualified reads remove nothing", b_empty_n, 1);
    rd_op(0, 1, 0);
    settle();
    chk_flags();

    // R5 R6 R7 R8: threshold boundaries for each preset, write while full, read while empty
    fill_drain();
    for (int s = 1; s < 4; s++) begin
      rst_seq(2'(s));
      fill_drain();
    end

    // constrained random sequential traffic
    rst_seq(2'd2);
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 5) wr_op(rnd36(), ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) != 0));
      else        rd_op(($urandom_range(0, 7) == 0), ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) == 0));
      if (i % 4 == 0) begin
        settle();
        chk_flags();
      end
    end
    settle();
    chk_flags();

    // R10: concurrent write and read on both clocks
    rst_seq(2'd3);
    got = 0;
    fork
      begin
        int sent = 0;
        while (sent < 200) begin
          @(negedge a_clk);
          if (a_full_n && $urandom_range(0, 3) != 0) begin
            a_d = rnd36(); a_sel_n = 0; a_en = 1; a_wr = 1;
            model.push_back(a_d);
            sent++;
          end else begin
            a_sel_n = 1; a_en = 0; a_wr = 0;
          end
        end
        @(negedge a_clk);
        a_sel_n = 1; a_en = 0; a_wr = 0;
      end
      begin
        while (got < 200) begin
          @(negedge b_clk);
          if (b_empty_n && $urandom_range(0, 3) != 0) begin
            b_sel_n = 0; b_en = 1; b_wr = 0;
            @(posedge b_clk);
            #0.3;
            b_sel_n = 1; b_en = 0;
            last_q = model.pop_front();
            chk(b_q === last_q, "R10 concurrent data order", b_q, last_q);
            got++;
          end
        end
      end
    join
    settle();
    chk(got == 200, "R10 all words returned", got, 200);
    chk_flags();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule